// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This block is the arithmetic slice of an integer execution pipe. It is purely combinational: a 7-bit function code chooses one operation, and the unit forms a 64-bit result from operand A and operand B in the same cycle. Operand B is either the register value or a small unsigned literal taken from the instruction. Add and subtract come in quadword (64-bit) and longword (32-bit) widths. Longword results are sign-extended to 64 bits. Some variants scale operand A by 4 or 8 first, and some raise an overflow flag.

The compare operations return a single truth bit. The bytewise compare returns one bit per byte lane. Any code the unit does not implement raises an illegal-function flag, which the decode stage uses to raise its own exception. The overflow flag goes to the trap logic, and the wrapped result is still driven so the writeback path does not need a special case.

Top module: `iacu_top`

## Requirements
- R1: Codes 0x20 (add) and 0x29 (subtract) return A+B and A−B modulo 2^64.
- R2: Codes 0x00 (add) and 0x09 (subtract) operate on bits 31:0 of both operands. Result bits 63:32 are copies of result bit 31.
- R3: Scaled codes multiply A by 4 or 8 (shifting out its upper bits) before the operation. Longword: add 0x02/0x12, subtract 0x0b/0x1b (×4/×8). Quadword: add 0x22/0x32, subtract 0x2b/0x3b (×4/×8).
- R4: Trapping adds 0x40 (longword) and 0x60 (quadword) assert the overflow flag exactly when the true signed sum does not fit the operation width.
- R5: Trapping subtracts 0x49 (longword) and 0x69 (quadword) assert the overflow flag exactly when the true signed difference does not fit the operation width.
- R6: A trapping variant drives the same wrapped result as its plain code, whether or not it overflows. No other code ever asserts the overflow flag.
- R7: Codes 0x2d (A==B), 0x6d (signed A≤B), 0x4d (signed A<B), 0x3d (unsigned A≤B) and 0x1d (unsigned A<B) return 1 when true and 0 when false.
- R8: Code 0x0f sets result bit i (i = 0..7) when unsigned byte i of A, bits 8i+7:8i, is at least byte i of B. Result bits 63:8 are zero.
- R9: When the literal-select input is 1, operand B is the 8-bit literal zero-extended to 64 bits, and the B register input has no effect.
- R10: Every code not listed above asserts the illegal flag, drives result zero, and leaves overflow low. Listed codes keep the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B register value |
| lit_i | input | 8 | Unsigned literal for operand B |
| lit_sel_i | input | 1 | 1 selects the literal as operand B |
| func_i | input | 7 | Function code |
| result_o | output | 64 | Operation result |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |
| illegal_o | output | 1 | Function code not implemented |

## Verification
The hardest cases to reach are the overflow boundaries of the longword trapping codes. There, the upper 32 bits of A and B must not matter, and a sum of exactly 0x7FFFFFFF must stay legal while one more must trap. The stimulus crosses every one of the 128 function codes with operand pairs drawn from a corner set. That set holds 0x7FFFFFFF, 0x80000000, values that are all ones in one half only, and the 64-bit extremes, so every sign combination at both widths is paired. Pseudo-random pairs and a sweep of literal values with deliberately noisy B register contents follow.

// File: rtl/iacu_pkg.sv
// Package: shared function codes and control types for the integer
// add/subtract/compare unit. The code values are architectural and fixed.
package iacu_pkg;

    localparam int FUNC_W = 7;

    // Add family
    localparam logic [FUNC_W-1:0] FC_ADD_L    = 7'h00;
    localparam logic [FUNC_W-1:0] FC_ADD_LV   = 7'h40;
    localparam logic [FUNC_W-1:0] FC_ADD_L4   = 7'h02;
    localparam logic [FUNC_W-1:0] FC_ADD_L8   = 7'h12;
    localparam logic [FUNC_W-1:0] FC_ADD_Q    = 7'h20;
    localparam logic [FUNC_W-1:0] FC_ADD_QV   = 7'h60;
    localparam logic [FUNC_W-1:0] FC_ADD_Q4   = 7'h22;
    localparam logic [FUNC_W-1:0] FC_ADD_Q8   = 7'h32;
    // Subtract family
    localparam logic [FUNC_W-1:0] FC_SUB_L    = 7'h09;
    localparam logic [FUNC_W-1:0] FC_SUB_LV   = 7'h49;
    localparam logic [FUNC_W-1:0] FC_SUB_L4   = 7'h0b;
    localparam logic [FUNC_W-1:0] FC_SUB_L8   = 7'h1b;
    localparam logic [FUNC_W-1:0] FC_SUB_Q    = 7'h29;
    localparam logic [FUNC_W-1:0] FC_SUB_QV   = 7'h69;
    localparam logic [FUNC_W-1:0] FC_SUB_Q4   = 7'h2b;
    localparam logic [FUNC_W-1:0] FC_SUB_Q8   = 7'h3b;
    // Compare family
    localparam logic [FUNC_W-1:0] FC_CMP_EQ   = 7'h2d;
    localparam logic [FUNC_W-1:0] FC_CMP_SLE  = 7'h6d;
    localparam logic [FUNC_W-1:0] FC_CMP_SLT  = 7'h4d;
    localparam logic [FUNC_W-1:0] FC_CMP_ULE  = 7'h3d;
    localparam logic [FUNC_W-1:0] FC_CMP_ULT  = 7'h1d;
    localparam logic [FUNC_W-1:0] FC_CMP_BYTE = 7'h0f;

    // Which datapath produces the result
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_CMP   = 2'd2,
        CLS_BYTES = 2'd3
    } unit_cls_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_SLE = 3'd1,
        CMP_SLT = 3'd2,
        CMP_ULE = 3'd3,
        CMP_ULT = 3'd4
    } cmp_kind_e;

    // Decoded control word
    typedef struct packed {
        unit_cls_e  cls;
        logic       sub;
        logic       longw;
        logic [1:0] scale;   // left shift applied to A: 0, 2 or 3
        logic       trap;
        cmp_kind_e  cmp;
    } iacu_ctrl_t;

endpackage

// File: rtl/iacu_decode.sv
// Module: iacu_decode
// Turns the 7-bit function code into a control word. Unlisted codes yield
// class CLS_NONE with every other field at its inactive value.
// Assumes: the caller has already routed only this unit's opcode group here.
module iacu_decode
    import iacu_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output iacu_ctrl_t        ctrl_o
);

    // Purpose: map each implemented code onto its datapath settings.
    always_comb begin
        ctrl_o       = '0;
        ctrl_o.cls   = CLS_NONE;
        ctrl_o.cmp   = CMP_EQ;
        unique case (func_i)
            FC_ADD_L:  begin ctrl_o.cls = CLS_ARITH; ctrl_o.longw = 1'b1; end
            FC_ADD_LV: begin ctrl_o.cls = CLS_ARITH; ctrl_o.longw = 1'b1; ctrl_o.trap = 1'b1; end
            FC_ADD_L4: begin ctrl_o.cls = CLS_ARITH; ctrl_o.longw = 1'b1; ctrl_o.scale = 2'd2; end
            FC_ADD_L8: begin ctrl_o.cls = CLS_ARITH; ctrl_o.longw = 1'b1; ctrl_o.scale = 2'd3; end
            FC_ADD_Q:  begin ctrl_o.cls = CLS_ARITH; end
            FC_ADD_QV: begin ctrl_o.cls = CLS_ARITH; ctrl_o.trap = 1'b1; end
            FC_ADD_Q4: begin ctrl_o.cls = CLS_ARITH; ctrl_o.scale = 2'd2; end
            FC_ADD_Q8: begin ctrl_o.cls = CLS_ARITH; ctrl_o.scale = 2'd3; end
            FC_SUB_L:  begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.longw = 1'b1; end
            FC_SUB_LV: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.longw = 1'b1; ctrl_o.trap = 1'b1; end
            FC_SUB_L4: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.longw = 1'b1; ctrl_o.scale = 2'd2; end
            FC_SUB_L8: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.longw = 1'b1; ctrl_o.scale = 2'd3; end
            FC_SUB_Q:  begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; end
            FC_SUB_QV: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.trap = 1'b1; end
            FC_SUB_Q4: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.scale = 2'd2; end
            FC_SUB_Q8: begin ctrl_o.cls = CLS_ARITH; ctrl_o.sub = 1'b1; ctrl_o.scale = 2'd3; end
            FC_CMP_EQ:   begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CMP_EQ;  end
            FC_CMP_SLE:  begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CMP_SLE; end
            FC_CMP_SLT:  begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CMP_SLT; end
            FC_CMP_ULE:  begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CMP_ULE; end
            FC_CMP_ULT:  begin ctrl_o.cls = CLS_CMP; ctrl_o.cmp = CMP_ULT; end
            FC_CMP_BYTE: begin ctrl_o.cls = CLS_BYTES; end
            default:     begin ctrl_o.cls = CLS_NONE; end
        endcase
    end

endmodule

// File: rtl/iacu_addsub.sv
// Module: iacu_addsub
// Scales A, adds or subtracts B, narrows to the low half with sign
// extension for longword operations, and flags signed overflow for the
// trapping variants. One shared adder serves both widths.
// Assumes: scale is only non-zero when trap is low.
module iacu_addsub #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              longw_i,
    input  logic [1:0]        scale_i,
    input  logic              trap_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);

    localparam int EXT_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] raw;
    logic              sgn_a;
    logic              sgn_b;
    logic              sgn_r;

    // Purpose: pre-scale A and run the shared adder/subtractor.
    always_comb begin
        a_sc = a_i << scale_i;
        raw  = sub_i ? (a_sc - b_i) : (a_sc + b_i);
    end

    // Purpose: narrow to the operation width with sign extension.
    always_comb begin
        if (longw_i) begin
            sum_o = {{EXT_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        end else begin
            sum_o = raw;
        end
    end

    // Purpose: derive the overflow flag from the operand and result signs.
    always_comb begin
        sgn_a = longw_i ? a_sc[HALF_W-1] : a_sc[DATA_W-1];
        sgn_b = longw_i ? b_i[HALF_W-1]  : b_i[DATA_W-1];
        sgn_r = longw_i ? raw[HALF_W-1]  : raw[DATA_W-1];
        ovf_o = trap_i & (sub_i ? (sgn_a != sgn_b) : (sgn_a == sgn_b)) & (sgn_r != sgn_a);
    end

    // Purpose: guard the width narrowing and the overflow sign rules.
    always_comb begin
        if (longw_i) begin
            AST_LONG_SEXT: assert (sum_o[DATA_W-1:HALF_W] == {EXT_W{sum_o[HALF_W-1]}})
                else $error("longword result not sign-extended"); // R2
        end
        if (ovf_o && !sub_i) begin
            AST_ADD_OVF_SIGNS: assert ((longw_i ? (a_i[HALF_W-1] == b_i[HALF_W-1])
                                                : (a_i[DATA_W-1] == b_i[DATA_W-1])))
                else $error("add overflow with operands of unlike sign"); // R4
        end
        if (ovf_o && sub_i) begin
            AST_SUB_OVF_SIGNS: assert ((longw_i ? (a_i[HALF_W-1] != b_i[HALF_W-1])
                                                : (a_i[DATA_W-1] != b_i[DATA_W-1])))
                else $error("subtract overflow with operands of like sign"); // R5
        end
    end

endmodule

// File: rtl/iacu_compare.sv
// Module: iacu_compare
// Whole-word signed/unsigned compares and the per-lane unsigned
// greater-or-equal mask. Both outputs are always computed; the top selects.
// Assumes: DATA_W is a multiple of LANE_W.
module iacu_compare
    import iacu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cmp_kind_e         kind_i,
    output logic              flag_o,
    output logic [LANES-1:0]  mask_o
);

    logic eq;
    logic slt;
    logic ult;

    // Purpose: compute the three primitive relations once.
    always_comb begin
        eq  = (a_i == b_i);
        slt = ($signed(a_i) < $signed(b_i));
        ult = (a_i < b_i);
    end

    // Purpose: combine the primitives into the selected relation.
    always_comb begin
        unique case (kind_i)
            CMP_EQ:  flag_o = eq;
            CMP_SLE: flag_o = slt | eq;
            CMP_SLT: flag_o = slt;
            CMP_ULE: flag_o = ult | eq;
            CMP_ULT: flag_o = ult;
            default: flag_o = 1'b0;
        endcase
    end

    // One unsigned comparator per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: lane g greater-or-equal test.
        always_comb begin
            mask_o[g] = (a_i[g*LANE_W +: LANE_W] >= b_i[g*LANE_W +: LANE_W]);
        end
    end

    // Purpose: the ordered relations must agree with equality.
    always_comb begin
        if (eq) begin
            AST_EQ_IMPLIES_LE: assert (mask_o == {LANES{1'b1}})
                else $error("equal operands gave a clear lane bit"); // R8
        end
    end

endmodule

// File: rtl/iacu_top.sv
// Module: iacu_top
// Integer add/subtract/compare unit. Selects operand B, decodes the function
// code, and muxes the arithmetic, compare or lane-mask result. Fully
// combinational; the caller registers the outputs.
// Assumes: LIT_W < DATA_W and DATA_W/LANE_W < DATA_W.
module iacu_top
    import iacu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32,
    parameter int LIT_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic              lit_sel_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o,
    output logic              illegal_o
);

    localparam int LANES = DATA_W / LANE_W;

    iacu_ctrl_t        ctrl;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic              cmp_flag;
    logic [LANES-1:0]  lane_mask;

    // Purpose: choose register or zero-extended literal as operand B.
    always_comb begin
        b_eff = lit_sel_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : opb_i;
    end

    iacu_decode i_decode (
        .func_i (func_i),
        .ctrl_o (ctrl)
    );

    iacu_addsub #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) i_addsub (
        .a_i     (opa_i),
        .b_i     (b_eff),
        .sub_i   (ctrl.sub),
        .longw_i (ctrl.longw),
        .scale_i (ctrl.scale),
        .trap_i  (ctrl.trap),
        .sum_o   (arith_res),
        .ovf_o   (arith_ovf)
    );

    iacu_compare #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) i_compare (
        .a_i    (opa_i),
        .b_i    (b_eff),
        .kind_i (ctrl.cmp),
        .flag_o (cmp_flag),
        .mask_o (lane_mask)
    );

    // Purpose: select the result of the active datapath.
    always_comb begin
        unique case (ctrl.cls)
            CLS_ARITH: result_o = arith_res;
            CLS_CMP:   result_o = {{(DATA_W-1){1'b0}}, cmp_flag};
            CLS_BYTES: result_o = {{(DATA_W-LANES){1'b0}}, lane_mask};
            default:   result_o = '0;
        endcase
    end

    // Purpose: qualify the flags with the decoded class.
    always_comb begin
        ovf_o     = (ctrl.cls == CLS_ARITH) & arith_ovf;
        illegal_o = (ctrl.cls == CLS_NONE);
    end

    // Purpose: guard the output mux against class leakage.
    always_comb begin
        if (illegal_o) begin
            AST_ILLEGAL_ZERO: assert (result_o == '0 && !ovf_o)
                else $error("illegal code drove data"); // R10
        end
        if (ovf_o) begin
            AST_OVF_TRAP_ONLY: assert (ctrl.trap && ctrl.scale == 2'd0)
                else $error("overflow on a non-trapping code"); // R6
        end
        if (ctrl.cls == CLS_CMP) begin
            AST_CMP_BOOL: assert (result_o[DATA_W-1:1] == '0)
                else $error("compare result not boolean"); // R7
        end
        if (ctrl.cls == CLS_BYTES) begin
            AST_BYTE_UPPER: assert (result_o[DATA_W-1:LANES] == '0)
                else $error("lane mask upper bits set"); // R8
        end
    end

endmodule

// File: tb/test_iacu_top.sv
// Bench: sweeps all 128 function codes against corner, random and literal
// operands, with expected values computed arithmetically.
module test_iacu_top;

    logic        clk = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [7:0]  lit = '0;
    logic        lit_sel = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] result;
    logic        ovf;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    iacu_top i_iacu_top (
        .opa_i     (opa),
        .opb_i     (opb),
        .lit_i     (lit),
        .lit_sel_i (lit_sel),
        .func_i    (func),
        .result_o  (result),
        .ovf_o     (ovf),
        .illegal_o (illegal)
    );

    function automatic logic [63:0] sx32(input logic [63:0] x);
        return {{32{x[31]}}, x[31:0]};
    endfunction

    // True signed range check at 32 bits
    function automatic logic ov32(input logic [63:0] a, input logic [63:0] b, input bit sub);
        longint x;
        x = sub ? (longint'($signed(a[31:0])) - longint'($signed(b[31:0])))
                : (longint'($signed(a[31:0])) + longint'($signed(b[31:0])));
        return (x > 64'sd2147483647) || (x < -64'sd2147483648);
    endfunction

    // Extended-precision check at 64 bits
    function automatic logic ov64(input logic [63:0] a, input logic [63:0] b, input bit sub);
        logic [64:0] x;
        x = sub ? ({a[63], a} - {b[63], b}) : ({a[63], a} + {b[63], b});
        return x[64] != x[63];
    endfunction

    task automatic model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic v, output logic il);
        r = '0; v = 1'b0; il = 1'b0;
        case (f)
            7'h00: r = sx32(a + b);
            7'h40: begin r = sx32(a + b); v = ov32(a, b, 0); end
            7'h02: r = sx32(a * 4 + b);
            7'h12: r = sx32(a * 8 + b);
            7'h20: r = a + b;
            7'h60: begin r = a + b; v = ov64(a, b, 0); end
            7'h22: r = a * 4 + b;
            7'h32: r = a * 8 + b;
            7'h09: r = sx32(a - b);
            7'h49: begin r = sx32(a - b); v = ov32(a, b, 1); end
            7'h0b: r = sx32(a * 4 - b);
            7'h1b: r = sx32(a * 8 - b);
            7'h29: r = a - b;
            7'h69: begin r = a - b; v = ov64(a, b, 1); end
            7'h2b: r = a * 4 - b;
            7'h3b: r = a * 8 - b;
            7'h2d: r = {63'd0, a == b};
            7'h6d: r = {63'd0, $signed(a) <= $signed(b)};
            7'h4d: r = {63'd0, $signed(a) < $signed(b)};
            7'h3d: r = {63'd0, a <= b};
            7'h1d: r = {63'd0, a < b};
            7'h0f: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
            default: il = 1'b1;
        endcase
    endtask

    function automatic string res_tag(input logic [6:0] f, input bit ls);
        if (ls) return "R9";
        case (f)
            7'h20, 7'h29: return "R1";
            7'h00, 7'h09: return "R2";
            7'h02, 7'h12, 7'h0b, 7'h1b, 7'h22, 7'h32, 7'h2b, 7'h3b: return "R3";
            7'h40, 7'h60, 7'h49, 7'h69: return "R6";
            7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d: return "R7";
            7'h0f: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [6:0] f);
        case (f)
            7'h40, 7'h60: return "R4";
            7'h49, 7'h69: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive one vector, then sample on the falling edge.
    task automatic run(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                       input bit ls, input logic [7:0] l);
        logic [63:0] er;
        logic ev, ei;
        @(posedge clk);
        func = f; opa = a; opb = b; lit_sel = ls; lit = l;
        model(f, a, ls ? {56'd0, l} : b, er, ev, ei);
        @(negedge clk);
        checks++;
        if (result !== er) begin
            failures++;
            $display("FAIL %s result f=%02h a=%h b=%h lit=%b/%02h actual=%h expected=%h",
                     res_tag(f, ls), f, a, b, ls, l, result, er);
        end
        if (ovf !== ev) begin
            failures++;
            $display("FAIL %s overflow f=%02h a=%h b=%h actual=%b expected=%b",
                     ovf_tag(f), f, a, b, ovf, ev);
        end
        if (illegal !== ei) begin
            failures++;
            $display("FAIL R10 illegal f=%02h actual=%b expected=%b", f, illegal, ei);
        end
    endtask

    logic [63:0] corner [12];
    logic [63:0] rnd = 64'h9E3779B97F4A7C15;

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        return t ^ (t << 17);
    endfunction

    initial begin
        corner[0]  = 64'h0;
        corner[1]  = 64'h1;
        corner[2]  = 64'h2;
        corner[3]  = 64'h0000_0000_7FFF_FFFF;
        corner[4]  = 64'h0000_0000_8000_0000;
        corner[5]  = 64'h0000_0000_FFFF_FFFF;
        corner[6]  = 64'h7FFF_FFFF_FFFF_FFFF;
        corner[7]  = 64'h8000_0000_0000_0000;
        corner[8]  = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[9]  = 64'h0123_4567_89AB_CDEF;
        corner[10] = 64'h4000_0000_0000_0000;
        corner[11] = 64'hFFFF_FFFF_4000_0000;

        // Idle state: all-zero inputs select a longword add of zeros (R2)
        #1;
        checks++;
        if (result !== 64'd0 || ovf !== 1'b0 || illegal !== 1'b0) begin
            failures++;
            $display("FAIL R2 idle actual=%h/%b/%b expected=0/0/0", result, ovf, illegal);
        end

        // Corner pairs across every code (R1..R8, R10)
        for (int f = 0; f < 128; f++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run(7'(f), corner[i], corner[j], 1'b0, 8'h00);

        // Random pairs; equal halves every fourth to hit equality cases
        for (int k = 0; k < 40; k++) begin
            logic [63:0] ra, rb;
            rnd = step(rnd); ra = rnd;
            rnd = step(rnd); rb = (k % 4 == 0) ? {ra[63:32], rnd[31:0]} : rnd;
            for (int f = 0; f < 128; f++)
                run(7'(f), ra, rb, 1'b0, 8'h00);
        end

        // Literal operand with noisy register B (R9)
        for (int l = 0; l < 256; l += 5)
            for (int f = 0; f < 128; f++) begin
                run(7'(f), 64'h0000_0000_7FFF_FF80, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 8'(l));
                run(7'(f), 64'hFFFF_FFFF_FFFF_FF00 | 64'(l), 64'h0, 1'b1, 8'(l ^ 8'h5A));
            end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule